// File: doc/BRIEF.md
# Programmable Clock Output Divider-Selector

This block is the digital back end of a small programmable clock generator. It receives a reference clock and a PLL output clock and divides each of them by twice a programmable 5-bit value. It then routes the results through two selection multiplexers to a main clock output and to a secondary output. The secondary output shares a single multifunction pin. A configuration field turns that pin into an output-enable input, an active-low power-down input, a frequency-select input that picks one of two stored divide values, or the second clock output.

The design uses a single clock. Both source clocks arrive as levels. They are brought into the system clock domain by synchronizers, and every divider counts the rising edges it detects. All widths therefore come out as whole multiples of the source periods. Every output pin has a data bit and an enable bit, which drive a tri-state pad. A configuration bit sets whether a disabled clock output floats or is driven low.

Top module: `clkgen_top`

## Requirements
- R1: While `rst` is high, `clk0_out`, `clk0_oe`, `mf_out` and `mf_oe` are all 0.
- R2: With `cfg_main_sel` = 0, `clk0_out` is the PLL clock divided by 2*P. Its high and low phases each last P PLL periods.
- R3: With `cfg_main_sel` = 1, `clk0_out` repeats the reference clock. With `cfg_main_sel` = 2 or 3, it is the reference divided by 2*P, with high and low phases of P reference periods each.
- R4: A P value of 0 divides in the same way as P = 1, so the smallest division is by 2.
- R5: With `cfg_pin_mode` = 3 the pin is a clock output and `mf_oe` is 1. `cfg_aux_sel` then picks the source of `mf_out`: 0 gives the reference, 1 the reference divided by 2, 2 the main output, and 3 the main output divided by 2.
- R6: With `cfg_pin_mode` 0, 1 or 2 the pin is an input, and `mf_oe` and `mf_out` are both 0.
- R7: With `cfg_pin_mode` = 0, `mf_in` = 0 disables the main output and `mf_in` = 1 lets it run.
- R8: A disabled main output has `clk0_oe` = 0 when `cfg_dis_hiz` = 1. When `cfg_dis_hiz` = 0 it has `clk0_oe` = 1 and `clk0_out` = 0. While the output is enabled, `clk0_oe` is 1.
- R9: With `cfg_pin_mode` = 1, `mf_in` = 0 stops every divider and puts the main output in its disabled state. When `mf_in` returns to 1, the dividers restart from zero with the output low. The first high phase is then a full one.
- R10: With `cfg_pin_mode` = 2, `mf_in` = 1 uses divide value `cfg_p_a` and `mf_in` = 0 uses `cfg_p_b`. In all other modes `cfg_p_a` is used.
- R11: A change of source selection or divide value takes effect only while the affected output is low. No high pulse shorter than a complete source high phase ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both source clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock level |
| pll_in | input | 1 | PLL output clock level |
| mf_in | input | 1 | Multifunction pin input value (the pad pull-up makes it 1 when undriven) |
| cfg_pin_mode | input | 2 | Pin role: 0 output enable, 1 power-down, 2 frequency select, 3 clock output |
| cfg_main_sel | input | 2 | Main output source: 0 PLL/2P, 1 reference, 2 or 3 reference/2P |
| cfg_aux_sel | input | 2 | Second output source: 0 reference, 1 reference/2, 2 main, 3 main/2 |
| cfg_p_a | input | PW | Divide value set selected by a frequency-select input of 1 |
| cfg_p_b | input | PW | Divide value set selected by a frequency-select input of 0 |
| cfg_dis_hiz | input | 1 | Disabled state: 1 floats the output, 0 drives it low |
| clk0_out | output | 1 | Main clock output data |
| clk0_oe | output | 1 | Main clock pad enable |
| mf_out | output | 1 | Multifunction pin output data |
| mf_oe | output | 1 | Multifunction pin pad enable |

## Verification
Two events can fall in the same cycle. One is a reconfiguration of the main output, either a source reselection or a new divide value. The other is a high phase of the source currently selected, or the divider's own terminal count. The bench changes the selection and the divide value at scattered, unaligned offsets against the running sources. After each change it records the narrowest high pulse seen on `clk0_out` and expects it to be no shorter than the shortest full high phase of any source. The bench also releases power-down at an arbitrary reference phase and judges both the delay to the first rising edge and the width of the first high phase that follows.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  typedef enum logic [1:0] {
    PIN_OE   = 2'd0,
    PIN_PD   = 2'd1,
    PIN_FSEL = 2'd2,
    PIN_CLK  = 2'd3
  } pin_mode_t;

  localparam int NSRC = 2;
  localparam int SRC_PLL = 0;
  localparam int SRC_REF = 1;

  localparam int NMUX = 4;
  localparam int MSEL_PLL_DIV = 0;
  localparam int MSEL_REF     = 1;
  localparam int MSEL_REF_DIV = 2;
  localparam int MSEL_SPARE   = 3;

  localparam int ASEL_REF       = 0;
  localparam int ASEL_REF_HALF  = 1;
  localparam int ASEL_MAIN      = 2;
  localparam int ASEL_MAIN_HALF = 3;
endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/clkgen_pdiv.sv
module clkgen_pdiv #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          lvl,
  input  logic [PW-1:0] p_in,
  output logic          q
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] p_act;
  logic [PW-1:0] p_eff;
  logic          prev;
  logic          tick;

  // zero divide value behaves as one
  assign p_eff = (p_in == '0) ? PW'(1) : p_in;
  assign tick  = lvl & ~prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      q     <= 1'b0;
      p_act <= p_eff;
    end else if (tick) begin
      if (cnt == p_act - PW'(1)) begin
        cnt <= '0;
        q   <= ~q;
        // new value is taken only as a low phase begins
        if (q) p_act <= p_eff;
      end else begin
        cnt <= cnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/clkgen_gmux.sv
module clkgen_gmux #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [N-1:0]  src,
  input  logic [SW-1:0] sel_cfg,
  output logic          q
);
  logic [SW-1:0] sel_act;
  logic          cur_low;
  logic          new_low;

  assign cur_low = ~src[sel_act];
  assign new_low = ~src[sel_cfg];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sel_act <= sel_cfg;
      q       <= 1'b0;
    end else begin
      q <= src[sel_act];
      if (cur_low && new_low) sel_act <= sel_cfg;
    end
  end
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int PW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          pll_in,
  input  logic          mf_in,
  input  logic [1:0]    cfg_pin_mode,
  input  logic [1:0]    cfg_main_sel,
  input  logic [1:0]    cfg_aux_sel,
  input  logic [PW-1:0] cfg_p_a,
  input  logic [PW-1:0] cfg_p_b,
  input  logic          cfg_dis_hiz,
  output logic          clk0_out,
  output logic          clk0_oe,
  output logic          mf_out,
  output logic          mf_oe
);
  pin_mode_t         mode;
  logic [SYNC_STAGES-1:0] mf_pipe;
  logic              mf_lvl;
  logic              run;
  logic              out_en;
  logic [PW-1:0]     p_sel;
  logic [NSRC-1:0]   src_raw;
  logic [NSRC-1:0]   src_lvl;
  logic [NSRC-1:0]   div_q;
  logic              ref_half_q;
  logic              main_q;
  logic              main_half_q;
  logic              aux_q;
  logic [NMUX-1:0]   main_src;
  logic [NMUX-1:0]   aux_src;

  assign mode = pin_mode_t'(cfg_pin_mode);

  // pin input synchronizer, resting at the pulled-up level
  always_ff @(posedge clk) begin
    if (rst) mf_pipe <= '1;
    else     mf_pipe <= {mf_pipe[SYNC_STAGES-2:0], mf_in};
  end
  assign mf_lvl = mf_pipe[SYNC_STAGES-1];

  assign run    = !((mode == PIN_PD) && !mf_lvl);
  assign out_en = run && !((mode == PIN_OE) && !mf_lvl);
  assign p_sel  = ((mode == PIN_FSEL) && !mf_lvl) ? cfg_p_b : cfg_p_a;

  assign src_raw[SRC_PLL] = pll_in;
  assign src_raw[SRC_REF] = ref_in;

  // one synchronizer and one 2*P divider per source clock
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    clkgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (src_raw[g]),
      .lvl (src_lvl[g])
    );
    clkgen_pdiv #(.PW(PW)) u_div (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .lvl  (src_lvl[g]),
      .p_in (p_sel),
      .q    (div_q[g])
    );
  end

  clkgen_pdiv #(.PW(PW)) u_ref_half (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .lvl  (src_lvl[SRC_REF]),
    .p_in (PW'(1)),
    .q    (ref_half_q)
  );

  always_comb begin
    main_src               = '0;
    main_src[MSEL_PLL_DIV] = div_q[SRC_PLL];
    main_src[MSEL_REF]     = src_lvl[SRC_REF];
    main_src[MSEL_REF_DIV] = div_q[SRC_REF];
    main_src[MSEL_SPARE]   = div_q[SRC_REF];
  end

  clkgen_gmux #(.N(NMUX)) u_main_mux (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .src     (main_src),
    .sel_cfg (cfg_main_sel),
    .q       (main_q)
  );

  clkgen_pdiv #(.PW(PW)) u_main_half (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .lvl  (main_q),
    .p_in (PW'(1)),
    .q    (main_half_q)
  );

  always_comb begin
    aux_src                 = '0;
    aux_src[ASEL_REF]       = src_lvl[SRC_REF];
    aux_src[ASEL_REF_HALF]  = ref_half_q;
    aux_src[ASEL_MAIN]      = main_q;
    aux_src[ASEL_MAIN_HALF] = main_half_q;
  end

  clkgen_gmux #(.N(NMUX)) u_aux_mux (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .src     (aux_src),
    .sel_cfg (cfg_aux_sel),
    .q       (aux_q)
  );

  // registered pad drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      clk0_out <= 1'b0;
      clk0_oe  <= 1'b0;
      mf_out   <= 1'b0;
      mf_oe    <= 1'b0;
    end else begin
      clk0_out <= out_en & main_q;
      clk0_oe  <= out_en | ~cfg_dis_hiz;
      mf_out   <= (mode == PIN_CLK) & aux_q;
      mf_oe    <= (mode == PIN_CLK);
    end
  end
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_pin_mode,
  input logic          cfg_dis_hiz,
  input logic          clk0_out,
  input logic          clk0_oe,
  input logic          mf_out,
  input logic          mf_oe,
  input logic          run,
  input logic          main_q,
  input logic [1:0]    main_sel_act,
  input logic          ref_div_q,
  input logic [PW-1:0] ref_div_p
);
  // R8
  drive_low_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_dis_hiz |=> clk0_oe);

  // R6
  pin_input_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_pin_mode != 2'd3) |=> (!mf_oe && !mf_out));

  // R5
  pin_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_pin_mode == 2'd3) |=> mf_oe);

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !clk0_out);

  // R11
  sel_low_chk: assert property (@(posedge clk) disable iff (rst)
    (main_sel_act != $past(main_sel_act)) |-> !main_q);

  // R11
  p_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_div_p != $past(ref_div_p)) |-> !ref_div_q);

  // R4
  p_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (ref_div_p != '0));
endmodule

bind clkgen_top clkgen_chk #(.PW(PW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_pin_mode (cfg_pin_mode),
  .cfg_dis_hiz  (cfg_dis_hiz),
  .clk0_out     (clk0_out),
  .clk0_oe      (clk0_oe),
  .mf_out       (mf_out),
  .mf_oe        (mf_oe),
  .run          (run),
  .main_q       (main_q),
  .main_sel_act (u_main_mux.sel_act),
  .ref_div_q    (div_q[1]),
  .ref_div_p    (g_src[1].u_div.p_act)
);

// File: tb/clkgen_top_test.sv
module clkgen_top_test;
  localparam int PW = 5;
  localparam int REF_H = 4;
  localparam int PLL_H = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic pll_in = 1'b0;
  logic mf_in = 1'b1;
  logic [1:0] cfg_pin_mode = 2'd0;
  logic [1:0] cfg_main_sel = 2'd2;
  logic [1:0] cfg_aux_sel = 2'd0;
  logic [PW-1:0] cfg_p_a = 5'd2;
  logic [PW-1:0] cfg_p_b = 5'd5;
  logic cfg_dis_hiz = 1'b1;
  logic clk0_out, clk0_oe, mf_out, mf_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkgen_top #(.PW(PW)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .pll_in(pll_in), .mf_in(mf_in),
    .cfg_pin_mode(cfg_pin_mode), .cfg_main_sel(cfg_main_sel),
    .cfg_aux_sel(cfg_aux_sel), .cfg_p_a(cfg_p_a), .cfg_p_b(cfg_p_b),
    .cfg_dis_hiz(cfg_dis_hiz), .clk0_out(clk0_out), .clk0_oe(clk0_oe),
    .mf_out(mf_out), .mf_oe(mf_oe)
  );

  // free-running source clocks, unrelated phases
  int rcnt = 0;
  int pcnt = 1;
  always @(negedge clk) begin
    rcnt <= (rcnt == REF_H - 1) ? 0 : rcnt + 1;
    if (rcnt == REF_H - 1) ref_in <= ~ref_in;
    pcnt <= (pcnt == PLL_H - 1) ? 0 : pcnt + 1;
    if (pcnt == PLL_H - 1) pll_in <= ~pll_in;
  end

  // width monitors
  logic c0_prev = 0, mf_prev = 0;
  int c0_len = 0, c0_hi = 0, c0_lo = 0, c0_edges = 0, c0_minhi = 1000;
  int mf_len = 0, mf_hi = 0, mf_lo = 0, mf_edges = 0;
  always @(negedge clk) begin
    if (clk0_out !== c0_prev) begin
      if (c0_prev) begin
        c0_hi = c0_len;
        if (c0_len < c0_minhi) c0_minhi = c0_len;
      end else c0_lo = c0_len;
      c0_len = 1;
      c0_edges++;
    end else c0_len++;
    c0_prev = clk0_out;
    if (mf_out !== mf_prev) begin
      if (mf_prev) mf_hi = mf_len; else mf_lo = mf_len;
      mf_len = 1;
      mf_edges++;
    end else mf_len++;
    mf_prev = mf_out;
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic settle_c0(input int n);
    int e;
    e = c0_edges;
    while (c0_edges < e + n) step(1);
  endtask

  task automatic settle_mf(input int n);
    int e;
    e = mf_edges;
    while (mf_edges < e + n) step(1);
  endtask

  task automatic widths_c0(input string tag, input int half);
    settle_c0(6);
    check({tag, " high"}, c0_hi, half);
    check({tag, " low"}, c0_lo, half);
  endtask

  task automatic t_reset();
    step(2);
    check("R1 clk0_out in reset", clk0_out, 0);
    check("R1 clk0_oe in reset", clk0_oe, 0);
    check("R1 mf_out in reset", mf_out, 0);
    check("R1 mf_oe in reset", mf_oe, 0);
    rst = 1'b0;
    step(3);
  endtask

  task automatic t_main();
    cfg_pin_mode = 2'd0; mf_in = 1'b1; cfg_p_a = 5'd3;
    cfg_main_sel = 2'd0; widths_c0("R2 pll/2P P=3", 3 * 2 * PLL_H);
    cfg_main_sel = 2'd1; widths_c0("R3 raw ref", REF_H);
    cfg_main_sel = 2'd2; widths_c0("R3 ref/2P P=3", 3 * 2 * REF_H);
    cfg_main_sel = 2'd3; widths_c0("R3 ref/2P sel3", 3 * 2 * REF_H);
    check("R8 clk0_oe while enabled", clk0_oe, 1);
  endtask

  task automatic t_pzero();
    cfg_main_sel = 2'd2; cfg_p_a = 5'd0;
    widths_c0("R4 P=0 acts as 1", 2 * REF_H);
  endtask

  task automatic t_aux();
    cfg_pin_mode = 2'd3; cfg_main_sel = 2'd2; cfg_p_a = 5'd2;
    step(4);
    check("R5 mf_oe in clock mode", mf_oe, 1);
    for (int s = 0; s < 4; s++) begin
      int exp_h;
      cfg_aux_sel = 2'(s);
      case (s)
        0: exp_h = REF_H;
        1: exp_h = 2 * REF_H;
        2: exp_h = 2 * 2 * REF_H;
        default: exp_h = 4 * 2 * REF_H;
      endcase
      settle_mf(6);
      check($sformatf("R5 aux sel %0d high", s), mf_hi, exp_h);
      check($sformatf("R5 aux sel %0d low", s), mf_lo, exp_h);
    end
  endtask

  task automatic t_inputs();
    mf_in = 1'b1;
    for (int m = 0; m < 3; m++) begin
      cfg_pin_mode = 2'(m);
      step(3);
      check($sformatf("R6 mf_oe mode %0d", m), mf_oe, 0);
      check($sformatf("R6 mf_out mode %0d", m), mf_out, 0);
    end
  endtask

  task automatic t_oe();
    int e;
    cfg_pin_mode = 2'd0; cfg_main_sel = 2'd2; cfg_p_a = 5'd2;
    cfg_dis_hiz = 1'b1; mf_in = 1'b0;
    step(6);
    e = c0_edges;
    step(60);
    check("R8 hiz disabled clk0_oe", clk0_oe, 0);
    check("R7 no edges while disabled", c0_edges - e, 0);
    check("R7 clk0_out low while disabled", clk0_out, 0);
    cfg_dis_hiz = 1'b0;
    step(3);
    e = c0_edges;
    step(60);
    check("R8 drive-low clk0_oe", clk0_oe, 1);
    check("R8 drive-low clk0_out", clk0_out, 0);
    check("R8 no edges drive-low", c0_edges - e, 0);
    mf_in = 1'b1;
    widths_c0("R7 re-enabled", 2 * 2 * REF_H);
    cfg_dis_hiz = 1'b1;
  endtask

  task automatic t_pd();
    int e, d;
    cfg_pin_mode = 2'd1; cfg_main_sel = 2'd2; cfg_p_a = 5'd2;
    cfg_dis_hiz = 1'b1; mf_in = 1'b0;
    step(8);
    e = c0_edges;
    step(50);
    check("R9 power-down clk0_oe", clk0_oe, 0);
    check("R9 power-down no edges", c0_edges - e, 0);
    step(3);
    mf_in = 1'b1;
    d = 0;
    while (clk0_out !== 1'b1) begin step(1); d++; end
    check_range("R9 delay to first rise", d, 1 * 2 * REF_H, 2 * 2 * REF_H + 12);
    check("R9 clk0_oe after release", clk0_oe, 1);
    e = c0_edges;
    while (c0_edges == e) step(1);
    check("R9 first high phase full", c0_hi, 2 * 2 * REF_H);
  endtask

  task automatic t_fsel();
    cfg_pin_mode = 2'd2; cfg_main_sel = 2'd2;
    cfg_p_a = 5'd2; cfg_p_b = 5'd5;
    mf_in = 1'b1; widths_c0("R10 select 1 uses set a", 2 * 2 * REF_H);
    mf_in = 1'b0; widths_c0("R10 select 0 uses set b", 5 * 2 * REF_H);
    mf_in = 1'b1;
  endtask

  task automatic t_glitch();
    cfg_pin_mode = 2'd0; mf_in = 1'b1;
    cfg_main_sel = 2'd0; cfg_p_a = 5'd3;
    settle_c0(4);
    c0_minhi = 1000;
    step(17); cfg_main_sel = 2'd1;
    step(13); cfg_main_sel = 2'd2;
    step(29); cfg_p_a = 5'd1;
    step(31); cfg_main_sel = 2'd0;
    step(23); cfg_p_a = 5'd4;
    step(7);  cfg_main_sel = 2'd1;
    step(11); cfg_p_a = 5'd2; cfg_main_sel = 2'd2;
    step(19); cfg_main_sel = 2'd0;
    settle_c0(6);
    check_range("R11 narrowest high pulse", c0_minhi, REF_H, 1000);
  endtask

  initial begin
    t_reset();
    t_main();
    t_pzero();
    t_aux();
    t_inputs();
    t_oe();
    t_pd();
    t_fsel();
    t_glitch();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule